// File: doc/BRIEF.md
# Aligned Divide-by-Two and Divide-by-Four/Six Clock Generator

This block derives two slower clocks from a single input clock. One output runs at half the input rate. The other runs at a quarter or a sixth of the input rate, and the `divsel` input chooses which. Both dividers are registered on the same rising input edge. Every rising edge of the slower output therefore lands on the same input edge as a rising edge of the half-rate output. A one-cycle marker, `phase_out`, flags each edge on which both outputs rise together. Downstream logic can use it to align its own sequencing to the divided clocks.

The enable is resampled on the falling input edge. The dividers can therefore only be started or stopped while the input clock is low, so a gated internal clock never produces a shortened pulse. While the dividers are stopped, both divided outputs keep their levels and the marker stays low.

The master reset `mr` is active high. It clears every register at once, without waiting for a clock edge. Its release passes through one register, so division restarts cleanly. Several instances that share one reset release come out in lockstep.

Top module: `clk_ratio_gen`

## Requirements
- R1: While running, `q_div2` inverts on every rising edge of `clk`, so it is high for one input cycle and low for the next.
- R2: With `divsel`=0 the slow output `q_div46` repeats every 4 input cycles: 2 high, then 2 low. With `divsel`=1 it repeats every 6 input cycles: 3 high, then 3 low.
- R3: Every rising edge of `q_div46` falls on the same input edge as a rising edge of `q_div2`.
- R4: When the enable captured on the falling edge is 0, both divided outputs hold their present levels on every rising edge.
- R5: `en` is sampled only on the falling edge of `clk`. A change made after a falling edge has no effect on the rising edge that follows it.
- R6: While `mr` is 1, `q_div2`, `q_div46` and `phase_out` are 0. This takes effect at once, without waiting for a clock edge.
- R7: After `mr` returns to 0 with `en` held at 1, the first rising edge of `clk` does nothing. Both divided outputs rise on the second rising edge.
- R8: `phase_out` is 1 for exactly one input cycle. It starts on each rising edge where `q_div2` and `q_div46` both go from 0 to 1.
- R9: A change of `divsel` takes effect only when the slow counter starts a new period. That is the edge on which `q_div46` rises. The period already in progress completes at its old length.
- R10: On any rising edge where the dividers are stopped, `phase_out` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock. Dividers advance on its rising edge, and the enable is sampled on its falling edge. |
| en | input | 1 | Divider enable, active high. |
| mr | input | 1 | Master reset, active high, asynchronous assertion. |
| divsel | input | 1 | Slow-output ratio: 0 selects divide by 4, 1 selects divide by 6. |
| q_div2 | output | 1 | Half-rate output. |
| q_div46 | output | 1 | Quarter-rate or sixth-rate output. |
| phase_out | output | 1 | One-cycle marker for coincident rising edges. |

## Verification
The dividers are run for long stretches in each ratio. This shows whether the count length, the duty split and the coincidence of rising edges are right. `divsel` is also flipped in the middle of a period and at irregular intervals, which tells a change taken at the period boundary from one taken at once. The enable is moved just after a falling edge in both directions, which tells falling-edge sampling from rising-edge sampling. The reset is raised in the middle of a cycle and then released, which separates asynchronous clearing from clocked clearing and confirms the restart delay of two rising edges.

// File: rtl/clk_ratio_pkg.sv
`timescale 1ns/1ps
// Package clk_ratio_pkg
// Shared types for the ratio clock generator. The ratio code names which of
// the two even division ratios the slow divider is currently counting.
package clk_ratio_pkg;

    typedef enum logic {
        RATIO_LO = 1'b0,   // first (smaller) even ratio
        RATIO_HI = 1'b1    // second (larger) even ratio
    } ratio_e;

endpackage

// File: rtl/clk_ratio_gate.sv
`timescale 1ns/1ps
// Module clk_ratio_gate
// Produces the run qualifier for both dividers.
// - The enable is captured on the falling clock edge, so run only changes
//   while the clock is low.
// - The reset release is registered on a rising edge, so division resumes
//   one edge after mr is released.
// Assumes: mr is active high and may assert at any time.
module clk_ratio_gate (
    input  logic clk,
    input  logic mr,
    input  logic en,
    output logic run
);

    logic en_fall_q;
    logic rel_q;

    // Capture the enable on the falling edge, cleared by master reset.
    always_ff @(negedge clk or posedge mr) begin
        if (mr) begin
            en_fall_q <= 1'b0;
        end else begin
            en_fall_q <= en;
        end
    end

    // Register the reset release on the rising edge.
    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            rel_q <= 1'b0;
        end else begin
            rel_q <= 1'b1;
        end
    end

    // Dividers advance only when released and enabled.
    assign run = en_fall_q & rel_q;

endmodule

// File: rtl/clk_ratio_half.sv
`timescale 1ns/1ps
// Module clk_ratio_half
// Divide-by-two stage: the output inverts on each rising edge where run is 1.
// Assumes: run changes only while clk is low.
module clk_ratio_half (
    input  logic clk,
    input  logic mr,
    input  logic run,
    output logic q
);

    logic q_q;

    // Toggle on every qualified rising edge, clear on master reset.
    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            q_q <= 1'b0;
        end else if (run) begin
            q_q <= ~q_q;
        end
    end

    assign q = q_q;

endmodule

// File: rtl/clk_ratio_even.sv
`timescale 1ns/1ps
// Module clk_ratio_even
// Even-ratio divider with a 50 % duty cycle. The ratio is DIV_LO or DIV_HI,
// chosen by sel. sel is sampled only when the counter starts a new period,
// so a ratio change never cuts a period short. The output is high for the
// first half of each period, so its rising edge is on the period-start edge.
// Assumes: DIV_LO and DIV_HI are even and at least 2.
module clk_ratio_even
    import clk_ratio_pkg::*;
#(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 6
) (
    input  logic clk,
    input  logic mr,
    input  logic run,
    input  logic sel,
    output logic q,
    output logic at_start
);

    localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CNT_W   = $clog2(DIV_MAX);
    localparam logic [CNT_W-1:0] TERM_LO = CNT_W'(DIV_LO - 1);
    localparam logic [CNT_W-1:0] TERM_HI = CNT_W'(DIV_HI - 1);
    localparam logic [CNT_W-1:0] HALF_LO = CNT_W'(DIV_LO / 2);
    localparam logic [CNT_W-1:0] HALF_HI = CNT_W'(DIV_HI / 2);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] half;
    ratio_e           mode_q;
    ratio_e           mode_nxt;
    logic             q_q;
    logic             q_nxt;

    // Choose the ratio for the coming step and derive the next count and level.
    always_comb begin
        mode_nxt = (cnt_q == '0) ? ratio_e'(sel) : mode_q;
        term     = (mode_nxt == RATIO_HI) ? TERM_HI : TERM_LO;
        half     = (mode_nxt == RATIO_HI) ? HALF_HI : HALF_LO;
        cnt_nxt  = (cnt_q == term) ? '0 : cnt_q + CNT_W'(1);
        q_nxt    = (cnt_nxt != '0) && (cnt_nxt <= half);
    end

    // Advance the counter, ratio and output on qualified rising edges.
    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            cnt_q  <= '0;
            mode_q <= RATIO_LO;
            q_q    <= 1'b0;
        end else if (run) begin
            cnt_q  <= cnt_nxt;
            mode_q <= mode_nxt;
            q_q    <= q_nxt;
        end
    end

    assign q        = q_q;
    assign at_start = (cnt_q == '0);

endmodule

// File: rtl/clk_ratio_mark.sv
`timescale 1ns/1ps
// Module clk_ratio_mark
// Phase marker. It is set for one cycle on the edge where the slow divider
// starts a period while the half-rate output is low, i.e. where both outputs
// rise together. It is cleared on any edge where the dividers are stopped.
module clk_ratio_mark (
    input  logic clk,
    input  logic mr,
    input  logic run,
    input  logic slow_start,
    input  logic half_q,
    output logic mark
);

    logic mark_q;

    // Register the coincident-rise condition for one cycle.
    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            mark_q <= 1'b0;
        end else begin
            mark_q <= run & slow_start & ~half_q;
        end
    end

    assign mark = mark_q;

endmodule

// File: rtl/clk_ratio_gen.sv
`timescale 1ns/1ps
// Module clk_ratio_gen
// Top level: a half-rate output and a selectable quarter/sixth-rate output,
// both registered on the same rising edge, plus a coincident-rise marker.
// Reset is the functional master reset mr (active high, asynchronous
// assertion, registered release).
module clk_ratio_gen #(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 6
) (
    input  logic clk,
    input  logic en,
    input  logic mr,
    input  logic divsel,
    output logic q_div2,
    output logic q_div46,
    output logic phase_out
);

    logic run;
    logic slow_start;

    clk_ratio_gate u_gate (
        .clk (clk),
        .mr  (mr),
        .en  (en),
        .run (run)
    );

    clk_ratio_half u_half (
        .clk (clk),
        .mr  (mr),
        .run (run),
        .q   (q_div2)
    );

    clk_ratio_even #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) u_even (
        .clk      (clk),
        .mr       (mr),
        .run      (run),
        .sel      (divsel),
        .q        (q_div46),
        .at_start (slow_start)
    );

    clk_ratio_mark u_mark (
        .clk        (clk),
        .mr         (mr),
        .run        (run),
        .slow_start (slow_start),
        .half_q     (q_div2),
        .mark       (phase_out)
    );

endmodule

// File: rtl/clk_ratio_gen_chk.sv
`timescale 1ns/1ps
// Module clk_ratio_gen_chk
// Property checker for clk_ratio_gen, attached with bind.
module clk_ratio_gen_chk (
    input logic clk,
    input logic mr,
    input logic run,
    input logic q_div2,
    input logic q_div46,
    input logic phase_out
);

    // R1: each qualified edge inverts the half-rate output.
    a_r1_half_toggles: assert property (@(posedge clk) disable iff (mr)
        run |=> (q_div2 != $past(q_div2)));

    // R3: the slow output never rises alone.
    a_r3_rise_aligned: assert property (@(posedge clk) disable iff (mr)
        $rose(q_div46) |-> $rose(q_div2));

    // R4: stopped dividers keep their levels.
    a_r4_hold_levels: assert property (@(posedge clk) disable iff (mr)
        !run |=> ($stable(q_div2) && $stable(q_div46)));

    // R6: reset keeps every output low.
    a_r6_reset_low: assert property (@(posedge clk)
        mr |-> (!q_div2 && !q_div46 && !phase_out));

    // R8: the marker accompanies a joint rise and lasts one cycle.
    a_r8_mark_on_joint_rise: assert property (@(posedge clk) disable iff (mr)
        phase_out |-> ($rose(q_div2) && $rose(q_div46)));

    a_r8_mark_single: assert property (@(posedge clk) disable iff (mr)
        phase_out |=> !phase_out);

    // R10: the marker is cleared while stopped.
    a_r10_mark_low_held: assert property (@(posedge clk) disable iff (mr)
        !run |=> !phase_out);

endmodule

bind clk_ratio_gen clk_ratio_gen_chk u_chk (
    .clk       (clk),
    .mr        (mr),
    .run       (run),
    .q_div2    (q_div2),
    .q_div46   (q_div46),
    .phase_out (phase_out)
);

// File: tb/tb_clk_ratio_gen.sv
`timescale 1ns/1ps
module tb_clk_ratio_gen;

    logic clk = 1'b0;
    logic en = 1'b0;
    logic mr = 1'b0;
    logic divsel = 1'b0;
    logic q_div2;
    logic q_div46;
    logic phase_out;

    int errors = 0;
    int checks = 0;

    // Bench-side expectation state, computed from the requirements.
    bit m_q2, m_q46, m_ph, m_rel, m_encap, m_mode;
    int m_cnt;
    bit prev_q2, prev_q46;

    clk_ratio_gen dut (
        .clk       (clk),
        .en        (en),
        .mr        (mr),
        .divsel    (divsel),
        .q_div2    (q_div2),
        .q_div46   (q_div46),
        .phase_out (phase_out)
    );

    // 250 MHz input clock.
    always #2 clk = ~clk;

    // R5: the expected enable is what is present at the falling edge.
    always @(negedge clk) m_encap = mr ? 1'b0 : en;

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%b exp=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One rising edge: update the expectation, then compare 1 ns later.
    task automatic step(string tag);
        bit run;
        int n;
        @(posedge clk);
        prev_q2  = m_q2;
        prev_q46 = m_q46;
        if (mr) begin
            m_q2 = 0; m_q46 = 0; m_ph = 0; m_rel = 0; m_cnt = 0; m_mode = 0;
        end else begin
            run = m_rel && m_encap;
            if (run) begin
                m_ph = (m_cnt == 0);
                if (m_cnt == 0) m_mode = divsel;
                n = m_mode ? 6 : 4;
                m_cnt = (m_cnt + 1) % n;
                m_q2 = !m_q2;
                m_q46 = (m_cnt >= 1) && (m_cnt <= n / 2);
            end else begin
                m_ph = 0;
            end
            m_rel = 1;
        end
        #1;
        check(tag, "q_div2", q_div2, m_q2);
        check(tag, "q_div46", q_div46, m_q46);
        check(tag, "phase_out", phase_out, m_ph);
        if (!prev_q46 && q_div46)
            check("R3", "q_div2 rise with q_div46", q_div2 && !prev_q2, 1'b1);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #0.5 mr = 1'b1;
        for (int i = 0; i < 3; i++) step("R6");

        // R7: release with enable high; outputs rise on the second edge.
        mr = 1'b0; en = 1'b1;
        step("R7");
        check("R7", "q_div2 still low after first edge", q_div2, 1'b0);
        step("R7");
        check("R7", "q_div2 high after second edge", q_div2, 1'b1);

        // R1/R2: divide by 4.
        for (int i = 0; i < 8; i++) step("R1");
        for (int i = 0; i < 9; i++) step("R2");

        // R9: switch to divide by 6 in the middle of a period.
        divsel = 1'b1;
        for (int i = 0; i < 24; i++) step("R9");
        for (int i = 0; i < 18; i++) step("R2");

        // R4 and R10: stop the dividers.
        en = 1'b0;
        for (int i = 0; i < 6; i++) step("R4");
        for (int i = 0; i < 4; i++) step("R10");

        // R5: enable set just after a falling edge is not seen by the next rising edge.
        #1.5 en = 1'b1;
        step("R5");
        step("R5");
        step("R5");
        #1.5 en = 1'b0;
        step("R5");
        step("R5");
        en = 1'b1;
        for (int i = 0; i < 6; i++) step("R8");

        // R6: asynchronous reset in the middle of a cycle.
        mr = 1'b1;
        #0.5;
        check("R6", "q_div2 async clear", q_div2, 1'b0);
        check("R6", "q_div46 async clear", q_div46, 1'b0);
        check("R6", "phase_out async clear", phase_out, 1'b0);
        step("R6");
        step("R6");
        mr = 1'b0;
        divsel = 1'b0;
        step("R7");
        step("R7");

        // R9: sweep with divsel flipping at irregular intervals.
        for (int i = 0; i < 400; i++) begin
            if ((i % 37) == 5) divsel = ~divsel;
            if ((i % 53) == 40) en = 1'b0;
            if ((i % 53) == 45) en = 1'b1;
            step("R9");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule